// File: doc/BRIEF.md
# Configurable Port Bus-Width Matcher

This block joins an external data port of selectable width to a memory array whose words are 36 bits wide and split into four 9-bit lanes. Two static strap inputs pick one of four widths: the whole 36-bit word, an 18-bit half word, a single 9-bit byte, or a mode in which the port keeps running but none of its I/Os are used. In the two narrow widths, one or two low-order select inputs act as extra address bits and choose which lanes of the stored word are reached.

A request is sampled on a clock edge together with its address, lane selects and write data. One cycle later the block presents the address, a request strobe, per-lane write enables and lane-steered write data to the memory. A narrow write enables only the lanes it selects, so the rest of the stored word is kept. For a read, the memory returns the word in the cycle after the request. The block then registers the selected lanes onto the low-order pins, together with a per-bit output-enable vector. That vector leaves every pin above the active width undriven, so the external buffer can three-state it.

Top module: `bus_width_matcher`

## Requirements
- R1: While reset is asserted, `pin_oe`, `mem_req` and `mem_lane_we` are all zero.
- R2: With `strap_match`=0 and `strap_size`=0 (full width), a write asserts `mem_lane_we`=4'b1111 and `mem_wdata` equals `pin_din`, whatever `sel_word` and `sel_byte` are.
- R3: In full width, a read drives the whole stored word on `pin_dout` with all 36 bits of `pin_oe` set, whatever the lane selects are.
- R4: With `strap_match`=1 and `strap_size`=0 (half width), a write takes `pin_din[17:0]`. `sel_word`=1 writes bits 35..18 (lane enables 4'b1100) and `sel_word`=0 writes bits 17..0 (4'b0011). `sel_byte` is ignored.
- R5: In half width, a read places the half chosen by `sel_word` on `pin_dout[17:0]`, with `pin_oe[17:0]` all ones and `pin_oe[35:18]` zero. `sel_byte` is ignored.
- R6: With both straps at 1 (byte width), a write takes `pin_din[8:0]` into lane n, bits 9n+8..9n, where n = {`sel_word`,`sel_byte`}. Only `mem_lane_we[n]` is set.
- R7: In byte width, a read places lane {`sel_word`,`sel_byte`} on `pin_dout[8:0]`, with `pin_oe[8:0]` all ones and `pin_oe[35:9]` zero.
- R8: With `strap_match`=0 and `strap_size`=1 (disabled I/O), writes assert no lane write enable and reads leave `pin_oe` all zero. The stored words stay unchanged.
- R9: Lanes whose write enable is not asserted keep their stored contents. This is observed by later full-width reads.
- R10: `pin_oe` is nonzero only in the cycle that follows the second clock edge after a read request is sampled, and `pin_dout` carries that read's data in the same cycle.
- R11: `mem_req` and `mem_addr` reflect the request and address sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_match | input | 1 | Static width strap: 0 = full or disabled, 1 = narrow |
| strap_size | input | 1 | Static size strap: selects disabled/full or byte/half |
| acc_valid | input | 1 | Request sampled this edge |
| acc_write | input | 1 | 1 = write request, 0 = read request |
| acc_addr | input | ADDR_W | Word address of the request |
| sel_word | input | 1 | Upper lane-select bit (half and byte widths) |
| sel_byte | input | 1 | Lower lane-select bit (byte width) |
| pin_din | input | 36 | Data arriving from the external pins |
| mem_rdata | input | 36 | Word returned by the memory in the cycle after a request |
| pin_dout | output | 36 | Data for the external pins, low-aligned in narrow widths |
| pin_oe | output | 36 | Per-bit output enable for `pin_dout` |
| mem_req | output | 1 | Memory access strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_lane_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 36 | Lane-steered write data |

## Verification
The assertions take for granted that the two straps are constant while a request is in flight, so that a write or read is judged against the width it was issued in. They also assume that the memory answers in the cycle after the request. The stimulus changes the straps only between sweeps, after at least two idle cycles. It models the memory as a combinational lookup on the registered address, and it issues one request at a time with the request inputs held steady across the sampling edge.

// File: rtl/bwm_pkg.sv
`timescale 1ns/1ps
package bwm_pkg;

  localparam int NUM_LANES = 4;

  // Encoding is {strap_match, strap_size}
  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_OFF  = 2'b01,
    MODE_HALF = 2'b10,
    MODE_BYTE = 2'b11
  } width_mode_e;

  typedef struct packed {
    logic hi;   // word-level select
    logic lo;   // byte-level select
  } lane_sel_t;

  // Lanes written by a write in the given width.
  function automatic logic [NUM_LANES-1:0] lane_enable(width_mode_e m, lane_sel_t s);
    logic [NUM_LANES-1:0] en;
    case (m)
      MODE_FULL: en = '1;
      MODE_HALF: en = s.hi ? 4'b1100 : 4'b0011;
      MODE_BYTE: en = 4'b0001 << {s.hi, s.lo};
      default:   en = '0;
    endcase
    return en;
  endfunction

  // Pin lane that feeds memory lane i on a write.
  function automatic logic [1:0] write_src(width_mode_e m, int i);
    logic [1:0] src;
    case (m)
      MODE_HALF: src = {1'b0, 1'(i % 2)};
      MODE_BYTE: src = 2'b00;
      default:   src = 2'(i);
    endcase
    return src;
  endfunction

  // Memory lane that feeds pin lane j on a read.
  function automatic logic [1:0] read_src(width_mode_e m, int j, lane_sel_t s);
    logic [1:0] src;
    case (m)
      MODE_HALF: src = {s.hi, 1'(j % 2)};
      MODE_BYTE: src = {s.hi, s.lo};
      default:   src = 2'(j);
    endcase
    return src;
  endfunction

  // Whether pin lane j is driven on a read.
  function automatic logic read_live(width_mode_e m, int j);
    logic live;
    case (m)
      MODE_FULL: live = 1'b1;
      MODE_HALF: live = (j < 2);
      MODE_BYTE: live = (j == 0);
      default:   live = 1'b0;
    endcase
    return live;
  endfunction

endpackage

// File: rtl/bwm_reset_sync.sv
`timescale 1ns/1ps
module bwm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bwm_mode_decode.sv
`timescale 1ns/1ps
module bwm_mode_decode
  import bwm_pkg::*;
(
  input  logic        strap_match,
  input  logic        strap_size,
  output width_mode_e mode
);

  always_comb begin
    case ({strap_match, strap_size})
      2'b00:   mode = MODE_FULL;
      2'b01:   mode = MODE_OFF;
      2'b10:   mode = MODE_HALF;
      default: mode = MODE_BYTE;
    endcase
  end

endmodule

// File: rtl/bwm_write_steer.sv
`timescale 1ns/1ps
module bwm_write_steer
  import bwm_pkg::*;
#(
  parameter  int LANE_W = 9,
  localparam int WORD_W = NUM_LANES * LANE_W
) (
  input  width_mode_e           mode,
  input  lane_sel_t             sel,
  input  logic                  is_write,
  input  logic [WORD_W-1:0]     din,
  output logic [WORD_W-1:0]     wdata,
  output logic [NUM_LANES-1:0]  lane_we
);

  logic [LANE_W-1:0] pin_lane [NUM_LANES];

  always_comb begin
    lane_we = is_write ? lane_enable(mode, sel) : '0;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [1:0] src;
    assign pin_lane[i] = din[i*LANE_W +: LANE_W];
    always_comb begin
      src = write_src(mode, i);
      wdata[i*LANE_W +: LANE_W] = pin_lane[src];
    end
  end

endmodule

// File: rtl/bwm_read_steer.sv
`timescale 1ns/1ps
module bwm_read_steer
  import bwm_pkg::*;
#(
  parameter  int LANE_W = 9,
  localparam int WORD_W = NUM_LANES * LANE_W
) (
  input  width_mode_e        mode,
  input  lane_sel_t          sel,
  input  logic [WORD_W-1:0]  rdata,
  output logic [WORD_W-1:0]  dout,
  output logic [WORD_W-1:0]  oe
);

  logic [LANE_W-1:0] mem_lane [NUM_LANES];

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_pin
    logic [1:0] src;
    logic       live;
    assign mem_lane[j] = rdata[j*LANE_W +: LANE_W];
    always_comb begin
      src  = read_src(mode, j, sel);
      live = read_live(mode, j);
      dout[j*LANE_W +: LANE_W] = live ? mem_lane[src] : '0;
      oe[j*LANE_W +: LANE_W]   = {LANE_W{live}};
    end
  end

endmodule

// File: rtl/bus_width_matcher.sv
`timescale 1ns/1ps
module bus_width_matcher
  import bwm_pkg::*;
#(
  parameter  int LANE_W = 9,
  parameter  int ADDR_W = 15,
  localparam int WORD_W = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_match,
  input  logic                 strap_size,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 sel_word,
  input  logic                 sel_byte,
  input  logic [WORD_W-1:0]    pin_din,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic [WORD_W-1:0]    pin_dout,
  output logic [WORD_W-1:0]    pin_oe,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [NUM_LANES-1:0] mem_lane_we,
  output logic [WORD_W-1:0]    mem_wdata
);

  logic        rst_n_sync;
  width_mode_e mode;
  lane_sel_t   req_sel;

  bwm_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bwm_mode_decode u_mode (
    .strap_match (strap_match),
    .strap_size  (strap_size),
    .mode        (mode)
  );

  assign req_sel = '{hi: sel_word, lo: sel_byte};

  // ---------------- request stage ----------------
  logic [WORD_W-1:0]    steer_wdata;
  logic [NUM_LANES-1:0] steer_we;

  bwm_write_steer #(.LANE_W(LANE_W)) u_wr (
    .mode     (mode),
    .sel      (req_sel),
    .is_write (acc_write),
    .din      (pin_din),
    .wdata    (steer_wdata),
    .lane_we  (steer_we)
  );

  logic                 req_q,   req_d;
  logic [ADDR_W-1:0]    addr_q,  addr_d;
  logic [NUM_LANES-1:0] we_q,    we_d;
  logic [WORD_W-1:0]    wdata_q, wdata_d;
  logic                 rd_pend_q, rd_pend_d;
  width_mode_e          rd_mode_q, rd_mode_d;
  lane_sel_t            rd_sel_q,  rd_sel_d;
  logic                 req_ce;

  always_comb begin
    req_ce    = acc_valid;
    req_d     = acc_valid;
    rd_pend_d = acc_valid & ~acc_write;
    we_d      = acc_valid ? steer_we : '0;
    addr_d    = acc_addr;
    wdata_d   = steer_wdata;
    rd_mode_d = mode;
    rd_sel_d  = req_sel;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      req_q     <= 1'b0;
      rd_pend_q <= 1'b0;
      we_q      <= '0;
    end else begin
      req_q     <= req_d;
      rd_pend_q <= rd_pend_d;
      we_q      <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_mode_q <= MODE_FULL;
      rd_sel_q  <= '0;
    end else if (req_ce) begin
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      rd_mode_q <= rd_mode_d;
      rd_sel_q  <= rd_sel_d;
    end
  end

  assign mem_req     = req_q;
  assign mem_addr    = addr_q;
  assign mem_lane_we = we_q;
  assign mem_wdata   = wdata_q;

  // ---------------- pin stage ----------------
  logic [WORD_W-1:0] steer_dout;
  logic [WORD_W-1:0] steer_oe;

  bwm_read_steer #(.LANE_W(LANE_W)) u_rd (
    .mode  (rd_mode_q),
    .sel   (rd_sel_q),
    .rdata (mem_rdata),
    .dout  (steer_dout),
    .oe    (steer_oe)
  );

  logic [WORD_W-1:0] dout_q, dout_d;
  logic [WORD_W-1:0] oe_q,   oe_d;
  logic              dout_ce;

  always_comb begin
    dout_ce = rd_pend_q;
    dout_d  = steer_dout;
    oe_d    = rd_pend_q ? steer_oe : '0;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      oe_q <= '0;
    end else begin
      oe_q <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      dout_q <= '0;
    end else if (dout_ce) begin
      dout_q <= dout_d;
    end
  end

  assign pin_dout = dout_q;
  assign pin_oe   = oe_q;

endmodule

// File: rtl/bwm_checker.sv
`timescale 1ns/1ps
module bwm_checker #(
  parameter  int LANE_W = 9,
  parameter  int ADDR_W = 15,
  localparam int WORD_W = 4 * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_match,
  input logic              strap_size,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [WORD_W-1:0] pin_oe,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_lane_we
);

  logic is_full, is_off, is_half, is_byte;
  assign is_full = !strap_match && !strap_size;
  assign is_off  = !strap_match &&  strap_size;
  assign is_half =  strap_match && !strap_size;
  assign is_byte =  strap_match &&  strap_size;

  // R1: nothing asserted while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pin_oe == '0 && !mem_req && mem_lane_we == '0);
    end
  end

  assert_full_all_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && is_full && $past(acc_write)) |-> (mem_lane_we == 4'b1111));

  assert_half_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && is_half && $past(acc_write)) |->
      (mem_lane_we == 4'b0011 || mem_lane_we == 4'b1100));

  assert_half_upper_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_half |-> (pin_oe[WORD_W-1:2*LANE_W] == '0));

  assert_byte_single_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && is_byte && $past(acc_write)) |-> ($countones(mem_lane_we) == 1));

  assert_byte_upper_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_byte |-> (pin_oe[WORD_W-1:LANE_W] == '0));

  assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_off |-> (mem_lane_we == '0 && pin_oe == '0));

  assert_read_no_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !$past(acc_write)) |-> (mem_lane_we == '0));

  assert_oe_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != '0) |-> $past(acc_valid && !acc_write, 2));

  assert_req_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (mem_req && mem_addr == $past(acc_addr)));

  assert_idle_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !mem_req);

endmodule

bind bus_width_matcher bwm_checker #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strap_match (strap_match),
  .strap_size  (strap_size),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_addr    (acc_addr),
  .pin_oe      (pin_oe),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_lane_we (mem_lane_we)
);

// File: tb/bus_width_matcher_test.sv
`timescale 1ns/1ps
module bus_width_matcher_test;

  localparam int LW = 9;
  localparam int WW = 4 * LW;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          strap_match, strap_size;
  logic          acc_valid, acc_write;
  logic [AW-1:0] acc_addr;
  logic          sel_word, sel_byte;
  logic [WW-1:0] pin_din, mem_rdata, pin_dout, pin_oe, mem_wdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_lane_we;

  bus_width_matcher #(.LANE_W(LW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .strap_match(strap_match), .strap_size(strap_size),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .sel_word(sel_word), .sel_byte(sel_byte), .pin_din(pin_din), .mem_rdata(mem_rdata),
    .pin_dout(pin_dout), .pin_oe(pin_oe), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_lane_we(mem_lane_we), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  // memory behind the block: combinational read, lane-masked write
  logic [WW-1:0] mem [DEPTH];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (mem_req) begin
      for (int l = 0; l < 4; l++)
        if (mem_lane_we[l]) mem[mem_addr][l*LW +: LW] <= mem_wdata[l*LW +: LW];
    end
  end

  int errors = 0;
  int checks = 0;
  logic [WW-1:0] expw [DEPTH];
  logic [1:0] cur_m;   // {match,size}

  logic          s_req;
  logic [AW-1:0] s_addr;
  logic [3:0]    s_we;
  logic [WW-1:0] s_wdata, s_dout, s_oe;

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] pat(input int s);
    logic [63:0] t;
    t = 64'(s + 1) * 64'h9E3779B97F4A7C15;
    return t[WW-1:0];
  endfunction

  function automatic logic [3:0] exp_we(input bit hi, input bit lo);
    case (cur_m)
      2'b00:   return 4'b1111;
      2'b10:   return hi ? 4'b1100 : 4'b0011;
      2'b11:   return 4'(1 << (2 * int'(hi) + int'(lo)));
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [WW-1:0] lane_mask(input logic [3:0] we);
    logic [WW-1:0] m;
    m = '0;
    for (int l = 0; l < 4; l++) if (we[l]) m[l*LW +: LW] = '1;
    return m;
  endfunction

  function automatic logic [WW-1:0] exp_wide(input logic [WW-1:0] d);
    case (cur_m)
      2'b10:   return {2{d[2*LW-1:0]}};
      2'b11:   return {4{d[LW-1:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [WW-1:0] exp_oe();
    case (cur_m)
      2'b00:   return '1;
      2'b10:   return lane_mask(4'b0011);
      2'b11:   return lane_mask(4'b0001);
      default: return '0;
    endcase
  endfunction

  function automatic logic [WW-1:0] exp_dout(input logic [WW-1:0] w, input bit hi, input bit lo);
    case (cur_m)
      2'b00:   return w;
      2'b10:   return hi ? WW'(w[WW-1:2*LW]) : WW'(w[2*LW-1:0]);
      2'b11:   return WW'(w[(2 * int'(hi) + int'(lo)) * LW +: LW]);
      default: return '0;
    endcase
  endfunction

  task automatic access(input bit wr, input bit hi, input bit lo, input int a, input logic [WW-1:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; sel_word = hi; sel_byte = lo;
    acc_addr = AW'(a); pin_din = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    s_req = mem_req; s_addr = mem_addr; s_we = mem_lane_we; s_wdata = mem_wdata;
    chk("R10 oe idle before read data", pin_oe, '0);
    chk("R11 request strobe", WW'(s_req), WW'(1));
    chk("R11 address", WW'(s_addr), WW'(a));
    @(negedge clk);
    s_dout = pin_dout; s_oe = pin_oe;
  endtask

  task automatic wr_chk(input string req, input bit hi, input bit lo, input int a, input logic [WW-1:0] d);
    logic [3:0]    we;
    logic [WW-1:0] m;
    we = exp_we(hi, lo);
    m  = lane_mask(we);
    access(1'b1, hi, lo, a, d);
    chk({req, " lane enables"}, WW'(s_we), WW'(we));
    chk({req, " write data"}, s_wdata & m, exp_wide(d) & m);
    chk({req, " R10 no oe on write"}, s_oe, '0);
    expw[a] = (expw[a] & ~m) | (exp_wide(d) & m);
  endtask

  task automatic rd_chk(input string req, input bit hi, input bit lo, input int a);
    logic [WW-1:0] oe;
    oe = exp_oe();
    access(1'b0, hi, lo, a, pin_din);
    chk({req, " lane enables on read"}, WW'(s_we), '0);
    chk({req, " output enables"}, s_oe, oe);
    chk({req, " read data"}, s_dout & oe, exp_dout(expw[a], hi, lo) & oe);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    strap_match = m[1]; strap_size = m[0]; cur_m = m;
    repeat (2) @(negedge clk);
  endtask

  task automatic full_verify();
    logic [1:0] keep;
    keep = cur_m;
    set_mode(2'b00);
    for (int a = 0; a < 4; a++) rd_chk("R9 stored word preserved", 1'b0, 1'b0, a);
    set_mode(keep);
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strap_match = 1'b0; strap_size = 1'b0; cur_m = 2'b00;
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    sel_word = 1'b0; sel_byte = 1'b0; pin_din = '0;
    for (int i = 0; i < DEPTH; i++) expw[i] = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset oe", pin_oe, '0);
    chk("R1 reset req", WW'(mem_req), '0);
    chk("R1 reset lane enables", WW'(mem_lane_we), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // full width: lane selects vary but must not matter
    for (int a = 0; a < 4; a++) wr_chk("R2 full write", a[1], a[0], a, pat(a));
    for (int a = 0; a < 4; a++) rd_chk("R3 full read", ~a[1], ~a[0], a);

    // half width
    set_mode(2'b10);
    for (int a = 0; a < 4; a++)
      for (int h = 0; h < 2; h++) begin
        wr_chk("R4 half write", h[0], ~h[0], a, pat(16 + a * 2 + h));
        rd_chk("R5 half read", h[0], h[0], a);
        rd_chk("R5 half read other", ~h[0], 1'b0, a);
      end
    full_verify();

    // byte width: write a growing subset of lanes per word
    set_mode(2'b11);
    for (int a = 0; a < 4; a++)
      for (int n = 0; n <= a; n++) begin
        wr_chk("R6 byte write", n[1], n[0], a, pat(40 + a * 4 + n));
        for (int r = 0; r < 4; r++) rd_chk("R7 byte read", r[1], r[0], a);
      end
    full_verify();

    // disabled I/O
    set_mode(2'b01);
    for (int a = 0; a < 4; a++)
      for (int n = 0; n < 4; n++) begin
        wr_chk("R8 disabled write", n[1], n[0], a, pat(80 + a * 4 + n));
        rd_chk("R8 disabled read", n[1], n[0], a);
      end
    full_verify();

    // exhaustive word/select sweep over all 16 addresses in full width
    set_mode(2'b00);
    for (int a = 0; a < DEPTH; a++) wr_chk("R2 full sweep", a[2], a[3], a, pat(200 + a));
    for (int a = 0; a < DEPTH; a++) rd_chk("R3 full sweep", a[0], a[1], a);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule